// File: doc/BRIEF.md
# Serial Receive Pattern-Match Start/Stop Detector

This block sits beside a serial receiver and decides, from the received bit stream alone, when a receive transfer begins and when it ends. On every sampled bit the newest bit is shifted into a history register. The most recent bits are then compared with a programmable start pattern and a programmable stop pattern. The number of bits compared comes from a length input that is capped at the history depth. There is no sync pin: a transfer opens when the start pattern shows up in the data.

Two end-of-transfer policies are selectable. In rewrite mode a transfer stays open until software rewrites the start pattern, which the surrounding register logic reports as a one-cycle rewrite strobe. That strobe closes the transfer and arms the detector again. In pattern-stop mode the transfer stays open until the stop pattern is matched. The detector then re-arms by itself. The block reports a receive-active level together with one-cycle start and stop pulses. Word assembly, frame sync, clocking and register decoding belong to other blocks.

Top module: `rx_pattern_gate`

## Requirements
- R1: After reset `active_o`, `start_o` and `stop_o` are 0, the history is cleared and the detector is armed for a start.
- R2: When the detector is armed, a bit sampled with `bit_en_i` high completes a start match if the last L sampled bits equal `pat_start_i[L-1:0]`. The newest bit is compared with bit 0 and the bit sampled L-1 samples earlier with bit L-1. `start_o` and `active_o` both go high in the clock cycle that follows that sampling edge.
- R3: Pattern bits at positions L and above never affect a match, and neither do history bits older than L samples.
- R4: L is `len_i` clamped to MAX_LEN (16), so a `len_i` of 20 compares 16 bits. A `len_i` of 0 disables all matching.
- R5: A match needs at least L bits sampled since the last reset, start, stop or accepted rewrite. The cleared history alone never produces a match.
- R6: `start_o` and `stop_o` are high for exactly one cycle and only follow an edge at which `bit_en_i` was high. Changes on `bit_i` while `bit_en_i` is low are not sampled.
- R7: When `stop_mode_i` is 0, `active_o` stays high until `rearm_i` is high at a clock edge. That edge clears `active_o` one cycle later without a stop pulse and re-arms the detector. Stop-pattern matches are ignored in this mode.
- R8: When `stop_mode_i` is 1 and a transfer is open, a stop match over L bits sampled after the start produces a one-cycle `stop_o`, clears `active_o` in the same cycle and re-arms the detector.
- R9: While a transfer is open, start-pattern matches produce no start pulse. `rearm_i` has no effect while armed, and none while open in pattern-stop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Bit-clock enable: `bit_i` is sampled when high |
| bit_i | input | 1 | Received data bit |
| len_i | input | 5 | Compare length, clamped to 16 |
| pat_start_i | input | 16 | Start pattern, bit 0 compared with the newest bit |
| pat_stop_i | input | 16 | Stop pattern, bit 0 compared with the newest bit |
| stop_mode_i | input | 1 | 0: end by rewrite strobe, 1: end by stop pattern |
| rearm_i | input | 1 | One-cycle strobe: start pattern rewritten |
| active_o | output | 1 | Receive transfer open |
| start_o | output | 1 | One-cycle pulse when a transfer opens |
| stop_o | output | 1 | One-cycle pulse when a stop match closes a transfer |

## Verification
An all-zero start pattern is fed right after reset. It shows whether the cleared history is mistaken for sampled bits. A start pattern with junk above the length tells masking apart from full-width comparison. Lengths of 0 and 20 probe the disable and the clamp. Idle toggling of `bit_i` with the enable low separates real sampling from free-running shifting. In rewrite mode, the start and stop patterns are repeated while a transfer is open, which shows that the open state blocks restarts and ignores the stop pattern. Long pseudo-random streams with random enables and strobes, run in both modes and compared cycle by cycle against a reference model, cover back-to-back starts and stops and the restart of the fill count.

// File: rtl/rxpg_pkg.sv
package rxpg_pkg;

    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_RUN   = 1'b1
    } rxpg_state_e;

    typedef struct packed {
        rxpg_state_e st;
        logic        start;
        logic        stop;
    } rxpg_ctl_t;

endpackage

// File: rtl/rxpg_history.sv
module rxpg_history #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          shift_i,
    input  logic          bit_i,
    input  logic          clr_cnt_i,
    output logic [W-1:0]  hist_nx_o,
    output logic [CW-1:0] cnt_nx_o
);

    localparam logic [CW-1:0] CNT_MAX = CW'(W);

    logic [W-1:0]  hist_d, hist_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        hist_d  = hist_q;
        cnt_inc = cnt_q;
        if (shift_i) begin
            hist_d = {hist_q[W-2:0], bit_i};
            if (cnt_q != CNT_MAX) begin
                cnt_inc = cnt_q + CW'(1);
            end
        end
        cnt_d = clr_cnt_i ? '0 : cnt_inc;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hist_q <= '0;
            cnt_q  <= '0;
        end else begin
            hist_q <= hist_d;
            cnt_q  <= cnt_d;
        end
    end

    assign hist_nx_o = hist_d;
    assign cnt_nx_o  = cnt_inc;

endmodule

// File: rtl/rxpg_match.sv
module rxpg_match #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  hist_i,
    input  logic [W-1:0]  pat_i,
    input  logic [CW-1:0] len_i,
    input  logic [CW-1:0] cnt_i,
    output logic          hit_o
);

    logic [W-1:0] mask;
    logic [W-1:0] diff;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            mask[i] = (CW'(i) < len_i);
        end
        diff  = (hist_i ^ pat_i) & mask;
        hit_o = (len_i != '0) && (cnt_i >= len_i) && (diff == '0);
    end

endmodule

// File: rtl/rx_pattern_gate.sv
module rx_pattern_gate
    import rxpg_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               bit_en_i,
    input  logic               bit_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [MAX_LEN-1:0] pat_start_i,
    input  logic [MAX_LEN-1:0] pat_stop_i,
    input  logic               stop_mode_i,
    input  logic               rearm_i,
    output logic               active_o,
    output logic               start_o,
    output logic               stop_o
);

    localparam int              NPAT   = 2;
    localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

    rxpg_ctl_t          ctl_d, ctl_q;
    logic               clr_cnt;
    logic [LEN_W-1:0]   eff_len;
    logic [MAX_LEN-1:0] hist_nx;
    logic [LEN_W-1:0]   cnt_nx;
    logic [MAX_LEN-1:0] pats [NPAT];
    logic [NPAT-1:0]    hit;

    assign eff_len = (len_i > LEN_CAP) ? LEN_CAP : len_i;
    assign pats[0] = pat_start_i;
    assign pats[1] = pat_stop_i;

    rxpg_history #(.W(MAX_LEN), .CW(LEN_W)) u_hist (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .shift_i   (bit_en_i),
        .bit_i     (bit_i),
        .clr_cnt_i (clr_cnt),
        .hist_nx_o (hist_nx),
        .cnt_nx_o  (cnt_nx)
    );

    for (genvar g = 0; g < NPAT; g++) begin : g_cmp
        rxpg_match #(.W(MAX_LEN), .CW(LEN_W)) u_match (
            .hist_i (hist_nx),
            .pat_i  (pats[g]),
            .len_i  (eff_len),
            .cnt_i  (cnt_nx),
            .hit_o  (hit[g])
        );
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        ctl_d.stop  = 1'b0;
        clr_cnt     = 1'b0;
        unique case (ctl_q.st)
            ST_ARMED: begin
                if (bit_en_i && hit[0]) begin
                    ctl_d.st    = ST_RUN;
                    ctl_d.start = 1'b1;
                    clr_cnt     = 1'b1;
                end
            end
            ST_RUN: begin
                if (!stop_mode_i) begin
                    if (rearm_i) begin
                        ctl_d.st = ST_ARMED;
                        clr_cnt  = 1'b1;
                    end
                end else if (bit_en_i && hit[1]) begin
                    ctl_d.st   = ST_ARMED;
                    ctl_d.stop = 1'b1;
                    clr_cnt    = 1'b1;
                end
            end
            default: ctl_d.st = ST_ARMED;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_ARMED, start: 1'b0, stop: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign active_o = (ctl_q.st == ST_RUN);
    assign start_o  = ctl_q.start;
    assign stop_o   = ctl_q.stop;

endmodule

// File: rtl/rxpg_checker.sv
module rxpg_checker #(
    parameter int LEN_W = 5
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             bit_en_i,
    input logic [LEN_W-1:0] len_i,
    input logic             stop_mode_i,
    input logic             rearm_i,
    input logic             active_o,
    input logic             start_o,
    input logic             stop_o
);

    p_start_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |=> !start_o);

    p_stop_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_o |=> !stop_o);

    p_start_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> $past(bit_en_i));

    p_stop_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_o |-> $past(bit_en_i));

    p_start_from_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> (active_o && !$past(active_o)));

    p_stop_mode_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_o |-> (!active_o && $past(active_o) && $past(stop_mode_i)));

    p_len_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> ($past(len_i) != '0));

    p_hold_mode0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && !stop_mode_i && !rearm_i) |=> active_o);

    p_active_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(active_o) |-> (stop_o || $past(rearm_i)));

    p_pulse_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(start_o && stop_o));

endmodule

bind rx_pattern_gate rxpg_checker #(.LEN_W(LEN_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_en_i    (bit_en_i),
    .len_i       (len_i),
    .stop_mode_i (stop_mode_i),
    .rearm_i     (rearm_i),
    .active_o    (active_o),
    .start_o     (start_o),
    .stop_o      (stop_o)
);

// File: tb/sim_rx_pattern_gate.sv
module sim_rx_pattern_gate;

    localparam int CLK_PERIOD = 10;
    localparam int ML = 16;
    localparam int LW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic          bit_v = 1'b0;
    logic [LW-1:0] len = '0;
    logic [ML-1:0] pat0 = '0;
    logic [ML-1:0] pat1 = '0;
    logic          mode = 1'b0;
    logic          rearm = 1'b0;
    logic          active, start, stop;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rx_pattern_gate u0 (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bit_en_i    (bit_en),
        .bit_i       (bit_v),
        .len_i       (len),
        .pat_start_i (pat0),
        .pat_stop_i  (pat1),
        .stop_mode_i (mode),
        .rearm_i     (rearm),
        .active_o    (active),
        .start_o     (start),
        .stop_o      (stop)
    );

    typedef struct {
        logic  s;
        logic  p;
        logic  a;
        string req;
    } exp_t;

    exp_t  q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // shadow configuration, applied only inside cyc
    logic [LW-1:0] c_len = '0;
    logic [ML-1:0] c_p0 = '0;
    logic [ML-1:0] c_p1 = '0;
    logic          c_mode = 1'b0;

    // reference model state
    logic [ML-1:0] m_hist = '0;
    int            m_fill = 0;
    bit            m_run = 0;

    function automatic bit m_hit(logic [ML-1:0] p, int l);
        if (l == 0 || m_fill < l) return 0;
        for (int i = 0; i < l; i++) begin
            if (m_hist[i] != p[i]) return 0;
        end
        return 1;
    endfunction

    task automatic cyc(input logic en, input logic b, input logic ra);
        exp_t e;
        int   l;
        @(negedge clk);
        bit_en = en; bit_v = b; rearm = ra;
        len = c_len; pat0 = c_p0; pat1 = c_p1; mode = c_mode;
        l = (c_len > ML) ? ML : int'(c_len);
        e.s = 0; e.p = 0; e.req = cur_req;
        if (m_run && !c_mode && ra) begin
            m_run = 0;
            m_fill = 0;
            if (en) m_hist = {m_hist[ML-2:0], b};
        end else if (en) begin
            m_hist = {m_hist[ML-2:0], b};
            if (m_fill < ML) m_fill++;
            if (!m_run && m_hit(c_p0, l)) begin
                e.s = 1; m_run = 1; m_fill = 0;
            end else if (m_run && c_mode && m_hit(c_p1, l)) begin
                e.p = 1; m_run = 0; m_fill = 0;
            end
        end
        e.a = m_run;
        q.push_back(e);
    endtask

    task automatic send_pat(input logic [ML-1:0] p, input int n);
        for (int i = n - 1; i >= 0; i--) cyc(1'b1, p[i], 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0);
    endtask

    // monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_chk++;
                if (start !== e.s || stop !== e.p || active !== e.a) begin
                    n_bad++;
                    $display("FAIL %s: start/stop/active = %b%b%b, expected %b%b%b at %0t",
                             e.req, start, stop, active, e.s, e.p, e.a, $time);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] step_lfsr(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        n_chk++;
        if (active !== 0 || start !== 0 || stop !== 0) begin
            n_bad++;
            $display("FAIL R1: outputs %b%b%b, expected 000", active, start, stop);
        end
        @(negedge clk); rst_n = 1'b1;

        // R5: all-zero pattern must not match on cleared history
        cur_req = "R5";
        c_len = 4; c_p0 = 16'h0; c_p1 = 16'hFFFF; c_mode = 0;
        cyc(1, 0, 0); cyc(1, 0, 0); cyc(1, 0, 0);
        cyc(1, 0, 0);                       // fourth bit: start expected
        // R9: repeat start pattern while open, no new start
        cur_req = "R9";
        send_pat(16'h0, 8);
        // R7: stop pattern ignored in rewrite mode
        cur_req = "R7";
        send_pat(16'hF, 6);
        idle(2);
        cyc(0, 0, 1);                        // rewrite strobe closes
        idle(2);

        // R6: bit toggles without enable are not sampled
        cur_req = "R6";
        c_len = 3; c_p0 = 16'h5;
        cyc(1, 1, 0); cyc(1, 0, 0);
        for (int i = 0; i < 6; i++) cyc(0, i[0], 0);
        cyc(1, 1, 0);                        // history 101 -> start
        cyc(0, 0, 1);
        // R9: rewrite while armed has no effect
        cur_req = "R9";
        cyc(0, 0, 1); cyc(1, 0, 0);

        // R2/R3: 8-bit pattern, junk above length
        cur_req = "R3";
        c_len = 8; c_p0 = 16'hFFA5;
        send_pat(16'h3C, 5);
        cur_req = "R2";
        send_pat(16'hA5, 8);
        idle(1);
        cyc(0, 0, 1);

        // R4: length zero disables, length 20 clamps to 16
        cur_req = "R4";
        c_len = 0; c_p0 = 16'h0;
        send_pat(16'h0, 16);
        c_len = 20; c_p0 = 16'hBEEF;
        send_pat(16'h1234, 16);
        send_pat(16'hBEEF, 16);
        cyc(0, 0, 1);

        // R8: pattern-stop mode
        cur_req = "R8";
        c_mode = 1; c_len = 6; c_p0 = 16'h2D; c_p1 = 16'h13;
        send_pat(16'h2D, 6);
        cyc(0, 0, 1);                        // strobe ignored while open in mode 1
        send_pat(16'h13, 6);
        send_pat(16'h2D, 6);
        send_pat(16'h13, 6);

        // random stream, pattern-stop mode
        cur_req = "R8";
        c_len = 3; c_p0 = 16'h5; c_p1 = 16'h3;
        for (int i = 0; i < 600; i++) begin
            lfsr = step_lfsr(lfsr);
            cyc(lfsr[0] | lfsr[3], lfsr[5], lfsr[7] & lfsr[9]);
        end
        // random stream, rewrite mode
        cur_req = "R7";
        c_mode = 0; c_len = 2; c_p0 = 16'h2;
        for (int i = 0; i < 600; i++) begin
            lfsr = step_lfsr(lfsr);
            cyc(lfsr[1] | lfsr[4], lfsr[6], lfsr[2] & lfsr[8] & lfsr[11]);
        end

        idle(3);
        repeat (2) @(posedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule